// File: doc/BRIEF.md
# Inter-core mailbox unit

The block holds a bank of mailbox registers used by processor cores to signal one another. Each core owns a small group of mailboxes. Any agent on the register bus can raise bits in a mailbox by writing to its set address. The owner acknowledges bits by writing to the clear address. Both operations act only on the bits written as one, so several senders can share one mailbox without read-modify-write races.

Every mailbox drives its own level interrupt line. The line is high for as long as the mailbox holds any nonzero bit, and it falls on the clock edge that clears the last bit. Routing these lines to a core's interrupt inputs is done outside the block.

The register port is a simple single-cycle bus. A write takes effect at the clock edge where `bus_we` is high. A read samples the mailbox at the clock edge where `bus_re` is high, and the value appears on `bus_rdata` after that edge.

Top module: `mbx_unit`

## Requirements
- R1: After reset every mailbox holds zero, every `mbox_irq` bit is low and `bus_rdata` is zero.
- R2: A write to set address 0x80 + 16*core + 4*box ORs `bus_wdata` into mailbox index core*4+box at the next clock edge. Bits already set stay set.
- R3: A write to clear address 0xC0 + 16*core + 4*box clears in that mailbox exactly the bits that are 1 in `bus_wdata`. All other bits are unchanged.
- R4: A read of a clear address returns the addressed mailbox's contents on `bus_rdata` one cycle after the read is sampled. `bus_rdata` holds its value while `bus_re` is low.
- R5: A read of a set address returns the addressed mailbox's contents in the same way as R4.
- R6: `mbox_irq[i]` is high exactly when mailbox i is nonzero. It follows the register in the same cycle, and it changes only after a write.
- R7: A write to an address outside both windows (byte address below 0x80) changes no mailbox. A read of such an address returns zero.
- R8: A set or clear write with `bus_wdata` equal to zero leaves the mailbox unchanged.
- R9: A read and a write in the same cycle return the mailbox contents as they were before the write.
- R10: The two low bits of `bus_addr` play no part in address decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data: bits to set or to clear |
| bus_rdata | output | 32 | Registered read data |
| mbox_irq | output | 16 | One level interrupt per mailbox, index core*4+box |

## Verification
The bound checker checks the following on every cycle, at the ports:
- Interrupts stay low after reset.
- A nonzero set write raises the targeted line.
- An all-ones clear write drops the targeted line.
- Writes outside the windows and idle cycles leave every line steady.
- A read returns zero exactly when the line of the addressed mailbox is low.

The assertions cannot see exact bit values. Only the bench scenarios can show:
- that a set accumulates with earlier sets;
- that a partial clear leaves the other bits alone;
- that a zero write changes nothing;
- that the set and clear windows read back the same word;
- that a read in the same cycle as a write returns the old value.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // Write kinds produced by the address decoder.
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_SET  = 2'd1,
    ACC_CLR  = 2'd2
  } acc_kind_t;

  // Byte address to 32-bit range test, widened so that window limits may
  // exceed the address width.
  function automatic logic in_range(input logic [31:0] a,
                                    input int unsigned lo,
                                    input int unsigned bytes);
    return (a >= lo) && (a < lo + bytes);
  endfunction

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_BOX  = 16,
  parameter int SET_BASE = 'h80,
  parameter int CLR_BASE = 'hC0,
  localparam int IDX_W   = $clog2(NUM_BOX),
  localparam int WIN_B   = NUM_BOX * 4
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_t         kind,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);

  logic [31:0] a32;
  logic        set_hit;
  logic        clr_hit;

  // The low two address bits are dropped, so only whole words are decoded.
  always_comb begin
    a32     = 32'(addr) & ~32'd3;
    set_hit = in_range(a32, SET_BASE, WIN_B);
    clr_hit = in_range(a32, CLR_BASE, WIN_B);
    hit     = set_hit | clr_hit;
    kind    = ACC_NONE;
    idx     = '0;
    if (set_hit) begin
      kind = ACC_SET;
      idx  = IDX_W'((a32 - SET_BASE) >> 2);
    end else if (clr_hit) begin
      kind = ACC_CLR;
      idx  = IDX_W'((a32 - CLR_BASE) >> 2);
    end
  end

endmodule

// File: rtl/mbx_bank.sv
module mbx_bank
  import mbx_pkg::*;
#(
  parameter int NUM_BOX = 16,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(NUM_BOX)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            we,
  input  acc_kind_t                       kind,
  input  logic [IDX_W-1:0]                idx,
  input  logic [DATA_W-1:0]               wdata,
  output logic [NUM_BOX-1:0][DATA_W-1:0]  boxes,
  output logic [NUM_BOX-1:0]              irq
);

  for (genvar i = 0; i < NUM_BOX; i++) begin : g_box
    logic              sel;
    logic [DATA_W-1:0] set_bits;
    logic [DATA_W-1:0] clr_bits;
    logic [DATA_W-1:0] word_q;

    always_comb begin
      sel      = we && (idx == IDX_W'(i));
      set_bits = (sel && kind == ACC_SET) ? wdata : '0;
      clr_bits = (sel && kind == ACC_CLR) ? wdata : '0;
    end

    // Clear is applied first and set last: a bit hit by both stays set.
    always_ff @(posedge clk) begin
      if (rst) word_q <= '0;
      else     word_q <= (word_q & ~clr_bits) | set_bits;
    end

    assign boxes[i] = word_q;
    assign irq[i]   = |word_q;
  end

endmodule

// File: rtl/mbx_rdport.sv
module mbx_rdport #(
  parameter int NUM_BOX = 16,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(NUM_BOX)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            re,
  input  logic                            hit,
  input  logic [IDX_W-1:0]                idx,
  input  logic [NUM_BOX-1:0][DATA_W-1:0]  boxes,
  output logic [DATA_W-1:0]               rdata
);

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= hit ? boxes[idx] : '0;
  end

endmodule

// File: rtl/mbx_unit.sv
module mbx_unit
  import mbx_pkg::*;
#(
  parameter int NUM_CORES    = 4,
  parameter int BOX_PER_CORE = 4,
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 8,
  parameter int SET_BASE     = 'h80,
  parameter int CLR_BASE     = 'hC0,
  localparam int NUM_BOX     = NUM_CORES * BOX_PER_CORE,
  localparam int IDX_W       = $clog2(NUM_BOX)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_BOX-1:0] mbox_irq
);

  acc_kind_t                      kind;
  logic                           hit;
  logic [IDX_W-1:0]               idx;
  logic [NUM_BOX-1:0][DATA_W-1:0] boxes;

  mbx_decode #(
    .ADDR_W(ADDR_W), .NUM_BOX(NUM_BOX),
    .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
  ) u_dec (
    .addr(bus_addr), .kind(kind), .hit(hit), .idx(idx)
  );

  mbx_bank #(.NUM_BOX(NUM_BOX), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst(rst), .we(bus_we), .kind(kind), .idx(idx),
    .wdata(bus_wdata), .boxes(boxes), .irq(mbox_irq)
  );

  mbx_rdport #(.NUM_BOX(NUM_BOX), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .re(bus_re), .hit(hit), .idx(idx),
    .boxes(boxes), .rdata(bus_rdata)
  );

endmodule

// File: rtl/mbx_unit_chk.sv
module mbx_unit_chk #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int NUM_BOX  = 16,
  parameter int SET_BASE = 'h80,
  parameter int CLR_BASE = 'hC0,
  localparam int IDX_W   = $clog2(NUM_BOX),
  localparam int WIN_B   = NUM_BOX * 4
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_we,
  input logic               bus_re,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic [NUM_BOX-1:0] mbox_irq
);

  logic [31:0]      a;
  logic             in_set;
  logic             in_clr;
  logic [IDX_W-1:0] box;

  always_comb begin
    a      = 32'(bus_addr);
    in_set = (a >= SET_BASE) && (a < SET_BASE + WIN_B);
    in_clr = (a >= CLR_BASE) && (a < CLR_BASE + WIN_B);
    box    = in_set ? IDX_W'((a - SET_BASE) / 4) : IDX_W'((a - CLR_BASE) / 4);
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> mbox_irq == '0);

  // R2
  set_raises_chk: assert property (@(posedge clk) disable iff (rst)
    bus_we && in_set && bus_wdata != '0 |=> mbox_irq[$past(box)]);

  // R3
  clear_drops_chk: assert property (@(posedge clk) disable iff (rst)
    bus_we && in_clr && bus_wdata == '1 |=> !mbox_irq[$past(box)]);

  // R6
  idle_steady_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_we |=> $stable(mbox_irq));

  // R7
  outside_steady_chk: assert property (@(posedge clk) disable iff (rst)
    bus_we && !in_set && !in_clr |=> $stable(mbox_irq));

  // R4
  read_empty_chk: assert property (@(posedge clk) disable iff (rst)
    bus_re && (in_set || in_clr) |=>
      ((bus_rdata == '0) == !$past(mbox_irq[box])));

endmodule

bind mbx_unit mbx_unit_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_BOX(NUM_BOX),
  .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .mbox_irq(mbox_irq)
);

// File: tb/sim_mbx_unit.sv
module sim_mbx_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        we = 1'b0;
  logic        re = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] irq;

  logic [31:0] model [NB];
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbx_unit u0 (
    .clk(clk), .rst(rst), .bus_we(we), .bus_re(re), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .mbox_irq(irq)
  );

  function automatic logic [7:0] set_a(int i);
    return 8'(32'h80 + 16 * (i / 4) + 4 * (i % 4));
  endfunction

  function automatic logic [7:0] clr_a(int i);
    return 8'(32'hC0 + 16 * (i / 4) + 4 * (i % 4));
  endfunction

  function automatic logic [15:0] irq_exp();
    logic [15:0] v;
    for (int i = 0; i < NB; i++) v[i] = (model[i] != 0);
    return v;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    re = 1'b1; addr = a;
    @(negedge clk);
    re = 1'b0;
    d = rdata;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog all actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    for (int i = 0; i < NB; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check("R1 irq", 32'(irq), 32'h0);
    check("R1 rdata", rdata, 32'h0);
    for (int i = 0; i < NB; i++) begin
      rd(clr_a(i), v);
      check("R1 mailbox", v, 32'h0);
    end

    // R2 and R6: first set into every mailbox, one at a time
    for (int i = 0; i < NB; i++) begin
      v = (32'h1 << i) | (32'h8000_0000 >> i);
      wr(set_a(i), v);
      model[i] = model[i] | v;
      check("R6 irq after set", 32'(irq), 32'(irq_exp()));
    end

    // R2: a second set accumulates; R4/R5: both windows read back the word
    for (int i = 0; i < NB; i++) begin
      v = 32'h00F0_0F00 ^ (32'(i) << 12);
      wr(set_a(i), v);
      model[i] = model[i] | v;
      rd(set_a(i), v);
      check("R5 set window read", v, model[i]);
      rd(clr_a(i), v);
      check("R4 clear window read", v, model[i]);
    end

    // R3: partial clear leaves the other bits untouched
    for (int i = 0; i < NB; i++) begin
      v = 32'h0F0F_0F0F << (i % 4);
      wr(clr_a(i), v);
      model[i] = model[i] & ~v;
      rd(clr_a(i), v);
      check("R3 partial clear", v, model[i]);
    end
    check("R6 irq after clears", 32'(irq), 32'(irq_exp()));

    // R8: zero-valued writes change nothing
    for (int i = 0; i < NB; i++) begin
      wr(set_a(i), 32'h0);
      wr(clr_a(i), 32'h0);
      rd(set_a(i), v);
      check("R8 zero write", v, model[i]);
    end

    // R7: writes and reads below the windows
    for (int a = 0; a < 'h80; a += 4) begin
      wr(8'(a), 32'hFFFF_FFFF);
      check("R7 irq after stray write", 32'(irq), 32'(irq_exp()));
      rd(8'(a), v);
      check("R7 stray read", v, 32'h0);
    end
    for (int i = 0; i < NB; i++) begin
      rd(clr_a(i), v);
      check("R7 mailbox intact", v, model[i]);
    end

    // R10: low address bits ignored
    wr(set_a(5) | 8'h3, 32'h0000_0004);
    model[5] = model[5] | 32'h4;
    rd(clr_a(5) | 8'h1, v);
    check("R10 unaligned address", v, model[5]);

    // R9: read and write in the same cycle return the old value
    @(negedge clk);
    we = 1'b1; re = 1'b1; addr = set_a(9); wdata = 32'h1234_0000;
    @(negedge clk);
    we = 1'b0; re = 1'b0;
    check("R9 read before write", rdata, model[9]);
    model[9] = model[9] | 32'h1234_0000;
    rd(set_a(9), v);
    check("R9 write landed", v, model[9]);

    // R4: rdata holds while no read is issued
    repeat (3) @(negedge clk);
    check("R4 rdata hold", rdata, model[9]);

    // R3/R6: full clear of every mailbox, checking the lines as they fall
    for (int i = 0; i < NB; i++) begin
      wr(clr_a(i), 32'hFFFF_FFFF);
      model[i] = '0;
      check("R3 irq after full clear", 32'(irq), 32'(irq_exp()));
    end
    check("R6 all low", 32'(irq), 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule